// File: doc/BRIEF.md
# Signed Fractional Sequential Divider

This block divides a double-length signed fraction by a single-length signed fraction. Every operand and result is two's complement, and its binary point sits just right of the sign bit. With the default width of 36, the dividend is 71 bits wide. It returns a 36-bit signed quotient fraction and a 36-bit signed remainder. The three values relate as follows, where all values are read as fractions: dividend = quotient × divisor + remainder × 2^-(W-1).

A caller places both operands on the inputs and pulses `start` while `ready` is high. The block then works as follows:
- It captures the operands.
- It forms their magnitudes in a one-cycle setup step. The same step detects a quotient that cannot be represented.
- It produces one quotient bit per cycle by restoring shift-and-subtract.
- It applies the sign rules in a final cycle.

A single-cycle `done` pulse marks the finished result. The results then stay on the outputs until the next accepted `start`.

Top module: `sfrac_div`

## Requirements
- R1: While reset (`rstN` low) is held, `ready` is 1, `done` is 0, `divCheck` is 0, and `quotient` and `remainder` are 0.
- R2: For a legal division, the quotient magnitude equals floor(|dividend| / |divisor|). In this formula, both operands are read as unsigned integer magnitudes of their two's complement values. The divisor magnitude is at most 2^(W-1).
- R3: The quotient is the two's complement negation of that magnitude exactly when bit W-1 of the divisor differs from bit 2W-2 of the dividend.
- R4: The remainder magnitude equals |dividend| − quotient magnitude × |divisor|, and it is always smaller than |divisor|.
- R5: A nonzero remainder is negative exactly when the dividend is negative. A zero remainder is always output as all zeros.
- R6: An accepted start (`start` high while `ready` is high at a rising edge) drops `ready`. For a legal division, `done` is high for exactly one cycle, W+1 rising edges after the accepting edge. `ready` returns one edge after `done`.
- R7: A division is illegal when the divisor is zero, or when |dividend| ≥ |divisor| × 2^(W-1). In that case `divCheck` rises together with a `done` pulse one edge after the accepting edge, and `quotient` and `remainder` keep their previous values.
- R8: `start` has no effect while `ready` is low. `quotient`, `remainder` and `divCheck` hold their values from `done` until the next accepted start, and `divCheck` clears on that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division; taken only while ready is high |
| dividend | input | 2W-1 (71) | Double-length signed fraction |
| divisor | input | W (36) | Signed fraction |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle pulse when the division finishes |
| quotient | output | W (36) | Signed fractional quotient |
| remainder | output | W (36) | Signed remainder, aligned to the dividend sign |
| divCheck | output | 1 | Quotient not representable or divisor zero |

## Verification
Operand pairs cover all four sign combinations, which separates the quotient negation rule from the remainder rule. Exact multiples with positive and negative dividends separate a true zero remainder from one that is wrongly given a sign. Operands at minus one, a zero divisor, a dividend exactly at the overflow bound and a zero dividend exercise the illegal-case detection and the widest magnitudes. A long run of pseudo-random pairs, plus a start pulsed in the middle of a busy division, shows that every quotient bit is produced and that a start while busy leaves the running division intact.

// File: rtl/sfrac_div_pkg.sv
package sfrac_div_pkg;
  // strobes from the sequencer to the arithmetic datapath
  typedef struct packed {
    logic load;   // capture operands
    logic setup;  // form magnitudes and signs
    logic step;   // one restoring iteration
    logic fix;    // apply signs, publish results
  } dpCtl_t;
endpackage

// File: rtl/sfrac_div_ctrl.sv
module sfrac_div_ctrl
  import sfrac_div_pkg::*;
#(
  parameter int FW = 36
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   errNow,
  output dpCtl_t ctl,
  output logic   ready,
  output logic   done
);
  localparam int ITERS = FW - 1;
  localparam int CW    = $clog2(ITERS);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ITER, S_FIX, S_FIN} state_t;
  state_t state;
  logic [CW-1:0] iterCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE:  if (start) state <= S_SETUP;
        S_SETUP: begin
          iterCnt <= '0;
          state   <= errNow ? S_FIN : S_ITER;
        end
        S_ITER: begin
          iterCnt <= iterCnt + CW'(1);
          if (iterCnt == CW'(ITERS - 1)) state <= S_FIX;
        end
        S_FIX:   state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load  = (state == S_IDLE) && start;
    ctl.setup = (state == S_SETUP);
    ctl.step  = (state == S_ITER);
    ctl.fix   = (state == S_FIX);
  end

  assign ready = (state == S_IDLE);
  assign done  = (state == S_FIN);

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6 R8: once busy, the block only becomes ready again through done
  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !done) |=> !ready);

  // R6: an accepted start always leaves the idle state
  a_r6_start_leaves_idle: assert property (@(posedge clk) disable iff (!rstN)
    (ready && start) |=> !ready);
endmodule

// File: rtl/sfrac_div_dp.sv
module sfrac_div_dp
  import sfrac_div_pkg::*;
#(
  parameter int FW = 36
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [2*FW-2:0] dividend,
  input  logic [FW-1:0] divisor,
  output logic          errNow,
  output logic [FW-1:0] quotient,
  output logic [FW-1:0] remainder,
  output logic          divCheck
);
  localparam int DW = 2 * FW - 1;  // dividend width
  localparam int M  = FW - 1;      // magnitude bits per fraction

  logic [DW-1:0] dvdReg;
  logic [FW-1:0] dvsReg;
  logic [DW-1:0] dvdMag;
  logic [FW-1:0] dvsMag;

  logic [M-1:0]  part;      // partial remainder
  logic [M-1:0]  low;       // dividend low half, becomes quotient
  logic [FW-1:0] dvsM;
  logic          qNeg, rNeg;

  logic [FW-1:0] trialIn;
  logic [FW:0]   diff;
  logic          qBit;

  always_comb begin
    dvdMag  = dvdReg[DW-1] ? (~dvdReg + DW'(1)) : dvdReg;
    dvsMag  = dvsReg[FW-1] ? (~dvsReg + FW'(1)) : dvsReg;
    errNow  = (dvsMag == '0) || (dvdMag[DW-1:M] >= dvsMag);
    trialIn = {part, low[M-1]};
    diff    = {1'b0, trialIn} - {1'b0, dvsM};
    qBit    = !diff[FW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvdReg    <= '0;
      dvsReg    <= '0;
      part      <= '0;
      low       <= '0;
      dvsM      <= '0;
      qNeg      <= 1'b0;
      rNeg      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      divCheck  <= 1'b0;
    end else begin
      if (ctl.load) begin
        dvdReg   <= dividend;
        dvsReg   <= divisor;
        divCheck <= 1'b0;
      end
      if (ctl.setup) begin
        part     <= dvdMag[DW-2:M];
        low      <= dvdMag[M-1:0];
        dvsM     <= dvsMag;
        qNeg     <= dvdReg[DW-1] ^ dvsReg[FW-1];
        rNeg     <= dvdReg[DW-1];
        divCheck <= errNow;
      end
      if (ctl.step) begin
        part <= qBit ? diff[M-1:0] : trialIn[M-1:0];
        low  <= {low[M-2:0], qBit};
      end
      if (ctl.fix) begin
        quotient  <= qNeg ? (~{1'b0, low} + FW'(1)) : {1'b0, low};
        remainder <= (rNeg && part != '0) ? (~{1'b0, part} + FW'(1)) : {1'b0, part};
      end
    end
  end

  // R4: the partial remainder never reaches the divisor magnitude
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> ({1'b0, part} < dvsM));

  // R5: a nonzero published remainder carries the dividend sign
  a_r5_rem_sign: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.fix) && remainder != '0) |-> (remainder[FW-1] == rNeg));

  // R3: a nonzero published quotient carries the sign product
  a_r3_quot_sign: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.fix) && quotient != '0) |-> (quotient[FW-1] == qNeg));

  // R7: an illegal division never publishes new results
  a_r7_hold_on_error: assert property (@(posedge clk) disable iff (!rstN)
    (divCheck && !ctl.load) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: rtl/sfrac_div.sv
module sfrac_div
  import sfrac_div_pkg::*;
#(
  parameter int FW = 36
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2*FW-2:0] dividend,
  input  logic [FW-1:0]   divisor,
  output logic            ready,
  output logic            done,
  output logic [FW-1:0]   quotient,
  output logic [FW-1:0]   remainder,
  output logic            divCheck
);
  dpCtl_t ctl;
  logic   errNow;

  sfrac_div_ctrl #(.FW(FW)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .errNow (errNow),
    .ctl    (ctl),
    .ready  (ready),
    .done   (done)
  );

  sfrac_div_dp #(.FW(FW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dividend  (dividend),
    .divisor   (divisor),
    .errNow    (errNow),
    .quotient  (quotient),
    .remainder (remainder),
    .divCheck  (divCheck)
  );
endmodule

// File: tb/sfrac_div_tb_top.sv
`timescale 1ns/1ps
module sfrac_div_tb_top;
  localparam int FW  = 36;
  localparam int DW  = 2 * FW - 1;
  localparam int XW  = DW + 1;
  localparam int LAT = FW + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] dvd = '0;
  logic [FW-1:0] dvs = '0;
  logic ready, done, divCheck;
  logic [FW-1:0] quotient, remainder;

  int passCnt = 0;
  int failCnt = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sfrac_div #(.FW(FW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dvd), .divisor(dvs),
    .ready(ready), .done(done), .quotient(quotient), .remainder(remainder),
    .divCheck(divCheck)
  );

  task automatic check(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", what, act, exp, $time);
    end
  endtask

  // Wide-integer reference following the requirements
  task automatic computeRef(input logic [DW-1:0] a, input logic [FW-1:0] b,
                            output logic [FW-1:0] q, output logic [FW-1:0] r,
                            output logic e);
    logic [XW-1:0] am, bm, qm, rm;
    am = a[DW-1] ? ((XW'(1) << DW) - {1'b0, a}) : {1'b0, a};
    bm = b[FW-1] ? ((XW'(1) << FW) - XW'(b)) : XW'(b);
    e  = (bm == '0) || (am >= (bm << (FW - 1)));
    q  = '0;
    r  = '0;
    if (!e) begin
      qm = am / bm;
      rm = am % bm;
      q  = qm[FW-1:0];
      if (a[DW-1] ^ b[FW-1]) q = -q;
      r  = rm[FW-1:0];
      if (a[DW-1] && r != '0) r = -r;
    end
  endtask

  // Cycle-by-cycle behavioural model
  logic mReady, mDone, mErr, pendErr;
  logic [FW-1:0] mQ, mR, pendQ, pendR;
  int mLeft;

  always @(posedge clk) begin : model
    logic [FW-1:0] tq, tr;
    logic te;
    if (!rstN) begin
      mReady <= 1'b1; mDone <= 1'b0; mLeft <= 0;
      mQ <= '0; mR <= '0; mErr <= 1'b0;
      pendQ <= '0; pendR <= '0; pendErr <= 1'b0;
    end else begin
      if (mDone) begin
        mDone  <= 1'b0;
        mReady <= 1'b1;
      end
      if (mReady && start) begin
        computeRef(dvd, dvs, tq, tr, te);
        pendQ <= tq; pendR <= tr; pendErr <= te;
        mReady <= 1'b0;
        mErr   <= 1'b0;
        mLeft  <= te ? 1 : LAT;
      end else if (mLeft > 0) begin
        mLeft <= mLeft - 1;
        if (mLeft == 1) begin
          mDone <= 1'b1;
          mErr  <= pendErr;
          if (!pendErr) begin
            mQ <= pendQ;
            mR <= pendR;
          end
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(ready == mReady, "R6 R8 ready", 128'(ready), 128'(mReady));
      check(done == mDone, "R6 done", 128'(done), 128'(mDone));
      check(quotient == mQ, "R2 R3 quotient", 128'(quotient), 128'(mQ));
      check(remainder == mR, "R4 R5 remainder", 128'(remainder), 128'(mR));
      check(divCheck == mErr, "R7 divCheck", 128'(divCheck), 128'(mErr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      failCnt++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  // Run one division and check results, sign rules and latency explicitly
  task automatic runDiv(input logic [DW-1:0] a, input logic [FW-1:0] b);
    logic [FW-1:0] eq, er;
    logic ee;
    int steps;
    computeRef(a, b, eq, er, ee);
    @(negedge clk);
    dvd = a; dvs = b; start = 1'b1;
    steps = 0;
    @(negedge clk);
    start = 1'b0;
    steps++;
    while (!done && steps < 200) begin
      @(negedge clk);
      steps++;
    end
    check(steps == (ee ? 1 : LAT) + 1, "R6 R7 latency", 128'(steps), 128'((ee ? 1 : LAT) + 1));
    check(divCheck == ee, "R7 error flag", 128'(divCheck), 128'(ee));
    if (!ee) begin
      check(quotient == eq, "R2 R3 quotient value", 128'(quotient), 128'(eq));
      check(remainder == er, "R4 R5 remainder value", 128'(remainder), 128'(er));
    end
    @(negedge clk);
  endtask

  localparam logic [DW-1:0] HALF_D  = DW'(1) << (DW - 2);  // +0.5
  localparam logic [FW-1:0] HALF_S  = FW'(1) << (FW - 2);  // +0.5
  localparam logic [FW-1:0] MINUS1  = FW'(1) << (FW - 1);  // -1.0
  localparam logic [DW-1:0] MINUS1D = DW'(1) << (DW - 1);  // -1.0

  initial begin
    logic [FW-1:0] holdQ, holdR, savedQ, tr;
    logic te;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready == 1'b1, "R1 ready in reset", 128'(ready), 128'(1));
    check(done == 1'b0, "R1 done in reset", 128'(done), 128'(0));
    check(divCheck == 1'b0, "R1 divCheck in reset", 128'(divCheck), 128'(0));
    check(quotient == '0, "R1 quotient in reset", 128'(quotient), 128'(0));
    check(remainder == '0, "R1 remainder in reset", 128'(remainder), 128'(0));
    rstN = 1'b1;
    @(negedge clk);

    // sign combinations (R2 R3 R4 R5)
    runDiv(HALF_D >> 1, HALF_S);                        // +0.25 / +0.5
    runDiv(-(HALF_D >> 1) - DW'(12345), HALF_S + 77);   // neg / pos
    runDiv((HALF_D >> 2) + DW'(999), -HALF_S);          // pos / neg
    runDiv(-(HALF_D >> 3) - DW'(5), -(HALF_S + 3));     // neg / neg
    // zero remainders, both dividend signs (R5)
    runDiv(DW'(FW'(1000)) * DW'(FW'(3)), FW'(1000));
    runDiv(-(DW'(FW'(77777)) * DW'(FW'(41))), FW'(77777));
    runDiv('0, HALF_S);                                 // zero dividend
    // widest magnitudes
    runDiv(HALF_D, MINUS1);                             // divisor -1.0
    runDiv(MINUS1D + DW'(1), MINUS1);                   // -(1-ulp) / -1.0
    // illegal cases (R7)
    runDiv(MINUS1D, MINUS1);                            // equal magnitudes
    runDiv(HALF_D, '0);                                 // zero divisor
    runDiv(DW'(HALF_S) << (FW - 1), HALF_S);            // exactly at bound
    runDiv((DW'(HALF_S) << (FW - 1)) - DW'(1), HALF_S); // just below bound

    // R8: start while busy is ignored
    computeRef(HALF_D >> 3, HALF_S + 11, savedQ, tr, te);
    @(negedge clk);
    dvd = HALF_D >> 3; dvs = HALF_S + 11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    dvd = MINUS1D + DW'(3); dvs = FW'(7); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(quotient == savedQ, "R8 busy start ignored", 128'(quotient), 128'(savedQ));
    holdQ = quotient; holdR = remainder;
    repeat (6) @(negedge clk);
    check(quotient == holdQ, "R8 quotient held", 128'(quotient), 128'(holdQ));
    check(remainder == holdR, "R8 remainder held", 128'(remainder), 128'(holdR));

    // pseudo-random pairs (R2 R3 R4 R5 R7)
    for (int i = 0; i < 60; i++) begin
      logic [95:0] ra;
      logic [63:0] rb;
      ra = {$urandom, $urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 3 != 0) ra = {{24{ra[95]}}, ra[95:24]} >>> (i % 5);
      runDiv(ra[DW-1:0], rb[FW-1:0]);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule